// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the combinational front of a fetch stage for a compact 32-bit instruction set whose instructions run from one to six bytes. Each cycle the fetch path hands it six bytes read from instruction memory at the current program counter, lowest address in the lowest byte lane, together with that program counter. The block splits the leading byte into an opcode and a function code and works out from the opcode class whether a register-specifier byte and a 4-byte constant follow. It then pulls the register IDs and the constant out of the right byte lanes and forms the address of the next sequential instruction.

The constant does not sit at a fixed lane. It begins directly after the leading byte when no register byte is present, and one byte later when one is. Opcodes outside the defined set are flagged so that the stage around the block can raise an exception. Memory, the register file and execution sit outside it.

Top module: `ifd_fetch_decode`

## Requirements
- R1: `opcode_o` equals the upper nibble of window byte 0 (`win_i[7:4]`) and `func_o` equals its lower nibble (`win_i[3:0]`), for every opcode including invalid ones.
- R2: For opcodes 2, 3, 4, 5, 6, 4'hA and 4'hB, `has_reg_o` is 1, `ra_o` is the upper nibble of window byte 1 (`win_i[15:12]`) and `rb_o` is its lower nibble (`win_i[11:8]`).
- R3: For every other opcode, including invalid ones, `has_reg_o` is 0 and both `ra_o` and `rb_o` read 4'h8, the no-register ID.
- R4: For opcodes 3, 4, 5, 7 and 8, `has_const_o` is 1 and `valc_o` is the 4 bytes starting at window byte 2 when a register byte is present, or at window byte 1 otherwise, assembled with the lower-addressed byte as the less significant.
- R5: For every other opcode, `has_const_o` is 0 and `valc_o` is zero, whatever the window holds.
- R6: `valp_o` is `pc_i` plus the instruction length: 1 for opcodes 0, 1 and 9; 2 for opcodes 2, 6, 4'hA and 4'hB; 5 for opcodes 7 and 8; 6 for opcodes 3, 4 and 5.
- R7: Opcodes 4'hC to 4'hF set `bad_op_o` to 1 and are treated as 1 byte long with no register byte and no constant; opcodes 0 to 4'hB leave `bad_op_o` at 0.
- R8: The addition for `valp_o` wraps modulo 2^32, so a program counter near the top of the address space gives a small next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the instruction's first byte |
| win_i | input | 48 | Six fetched bytes, byte k at bits [8k+7:8k] |
| opcode_o | output | 4 | Opcode nibble |
| func_o | output | 4 | Function nibble |
| has_reg_o | output | 1 | Register-specifier byte present |
| has_const_o | output | 1 | 4-byte constant present |
| ra_o | output | 4 | First register ID, 4'h8 when absent |
| rb_o | output | 4 | Second register ID, 4'h8 when absent |
| valc_o | output | 32 | Constant word, zero when absent |
| valp_o | output | 32 | Address of the next sequential instruction |
| bad_op_o | output | 1 | Opcode outside the defined set |

## Verification
Every output is a pure function of the window and the program counter with no register on the path, so each result is due in the same cycle its stimulus is applied. The bench drives a new window and program counter just after a falling clock edge and compares all outputs one time unit later, well before the next rising edge, so settled values are read and no edge ordering matters. The vector table places distinctive bytes in the lanes a wrong offset would pick up, and a sweep of all sixteen opcodes over a fixed window checks the class decode against a model derived from the requirement lists.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

  localparam int unsigned OP_W     = 4;
  localparam int unsigned REG_ID_W = 4;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LEN_W    = 3;

  localparam logic [REG_ID_W-1:0] REG_NONE = 4'h8;

  typedef enum logic [OP_W-1:0] {
    OPC_NOP   = 4'h0,
    OPC_HALT  = 4'h1,
    OPC_MOVRR = 4'h2,
    OPC_MOVIR = 4'h3,
    OPC_STORE = 4'h4,
    OPC_LOAD  = 4'h5,
    OPC_ALU   = 4'h6,
    OPC_JUMP  = 4'h7,
    OPC_CALL  = 4'h8,
    OPC_RET   = 4'h9,
    OPC_PUSH  = 4'hA,
    OPC_POP   = 4'hB
  } opc_e;

  typedef struct packed {
    logic             valid;
    logic             has_reg;
    logic             has_const;
    logic [LEN_W-1:0] len;
  } opclass_t;

endpackage

// File: rtl/ifd_opclass.sv
module ifd_opclass
  import ifd_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output opclass_t        cls_o
);

  always_comb begin
    cls_o = '{valid: 1'b0, has_reg: 1'b0, has_const: 1'b0, len: LEN_W'(1)};
    case (opcode_i)
      OPC_NOP, OPC_HALT, OPC_RET:
        cls_o = '{valid: 1'b1, has_reg: 1'b0, has_const: 1'b0, len: LEN_W'(1)};
      OPC_MOVRR, OPC_ALU, OPC_PUSH, OPC_POP:
        cls_o = '{valid: 1'b1, has_reg: 1'b1, has_const: 1'b0, len: LEN_W'(2)};
      OPC_JUMP, OPC_CALL:
        cls_o = '{valid: 1'b1, has_reg: 1'b0, has_const: 1'b1, len: LEN_W'(5)};
      OPC_MOVIR, OPC_STORE, OPC_LOAD:
        cls_o = '{valid: 1'b1, has_reg: 1'b1, has_const: 1'b1, len: LEN_W'(6)};
      default:
        cls_o = '{valid: 1'b0, has_reg: 1'b0, has_const: 1'b0, len: LEN_W'(1)};
    endcase
  end

endmodule

// File: rtl/ifd_field_extract.sv
module ifd_field_extract
  import ifd_pkg::*;
#(
  parameter int unsigned WIN_BYTES   = 6,
  parameter int unsigned CONST_BYTES = 4,
  localparam int unsigned WIN_W      = WIN_BYTES * BYTE_W,
  localparam int unsigned CONST_W    = CONST_BYTES * BYTE_W
) (
  input  logic [WIN_W-1:0]    win_i,
  input  logic                has_reg_i,
  input  logic                has_const_i,
  output logic [REG_ID_W-1:0] ra_o,
  output logic [REG_ID_W-1:0] rb_o,
  output logic [CONST_W-1:0]  valc_o
);

  logic [BYTE_W-1:0]  lane [WIN_BYTES];
  logic [CONST_W-1:0] raw_const;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_lane
    assign lane[b] = win_i[b*BYTE_W +: BYTE_W];
  end

  // Constant byte k comes from lane 1+k, shifted one lane on when a
  // register byte sits in front of it.
  for (genvar k = 0; k < CONST_BYTES; k++) begin : g_const
    assign raw_const[k*BYTE_W +: BYTE_W] = has_reg_i ? lane[k + 2] : lane[k + 1];
  end

  always_comb begin
    ra_o   = has_reg_i ? lane[1][BYTE_W-1:REG_ID_W] : REG_NONE;
    rb_o   = has_reg_i ? lane[1][REG_ID_W-1:0]      : REG_NONE;
    valc_o = has_const_i ? raw_const : '0;
  end

  // lane 0 is decoded elsewhere
  logic unused_lane0;
  assign unused_lane0 = ^lane[0];

endmodule

// File: rtl/ifd_next_addr.sv
module ifd_next_addr
  import ifd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] valp_o
);

  always_comb begin
    valp_o = pc_i + ADDR_W'(len_i);
  end

endmodule

// File: rtl/ifd_fetch_decode.sv
module ifd_fetch_decode
  import ifd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned WIN_BYTES   = 6,
  parameter int unsigned CONST_BYTES = 4,
  localparam int unsigned WIN_W      = WIN_BYTES * BYTE_W,
  localparam int unsigned CONST_W    = CONST_BYTES * BYTE_W
) (
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [WIN_W-1:0]    win_i,
  output logic [OP_W-1:0]     opcode_o,
  output logic [OP_W-1:0]     func_o,
  output logic                has_reg_o,
  output logic                has_const_o,
  output logic [REG_ID_W-1:0] ra_o,
  output logic [REG_ID_W-1:0] rb_o,
  output logic [CONST_W-1:0]  valc_o,
  output logic [ADDR_W-1:0]   valp_o,
  output logic                bad_op_o
);

  opclass_t cls;

  assign opcode_o    = win_i[BYTE_W-1:OP_W];
  assign func_o      = win_i[OP_W-1:0];
  assign has_reg_o   = cls.has_reg;
  assign has_const_o = cls.has_const;
  assign bad_op_o    = ~cls.valid;

  ifd_opclass u_opclass (
    .opcode_i (opcode_o),
    .cls_o    (cls)
  );

  ifd_field_extract #(
    .WIN_BYTES   (WIN_BYTES),
    .CONST_BYTES (CONST_BYTES)
  ) u_extract (
    .win_i       (win_i),
    .has_reg_i   (cls.has_reg),
    .has_const_i (cls.has_const),
    .ra_o        (ra_o),
    .rb_o        (rb_o),
    .valc_o      (valc_o)
  );

  ifd_next_addr #(
    .ADDR_W (ADDR_W)
  ) u_next (
    .pc_i   (pc_i),
    .len_i  (cls.len),
    .valp_o (valp_o)
  );

endmodule

// File: rtl/ifd_fetch_decode_chk.sv
module ifd_fetch_decode_chk
  import ifd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WIN_W   = 48,
  parameter int unsigned CONST_W = 32
) (
  input logic [ADDR_W-1:0]   pc_i,
  input logic [WIN_W-1:0]    win_i,
  input logic [OP_W-1:0]     opcode_o,
  input logic [OP_W-1:0]     func_o,
  input logic                has_reg_o,
  input logic                has_const_o,
  input logic [REG_ID_W-1:0] ra_o,
  input logic [REG_ID_W-1:0] rb_o,
  input logic [CONST_W-1:0]  valc_o,
  input logic [ADDR_W-1:0]   valp_o,
  input logic                bad_op_o
);

  logic [ADDR_W-1:0] step;
  assign step = valp_o - pc_i;

  always_comb begin
    AST_OPCODE_SPLIT: assert ({opcode_o, func_o} == win_i[7:0]); // R1
    AST_REG_LANE: assert (!has_reg_o || (ra_o == win_i[15:12] && rb_o == win_i[11:8])); // R2
    AST_NOREG_IDS: assert (has_reg_o || (ra_o == REG_NONE && rb_o == REG_NONE)); // R3
    AST_CONST_LANE: assert (!has_const_o || valc_o == (has_reg_o ? win_i[47:16] : win_i[39:8])); // R4
    AST_NOCONST_ZERO: assert (has_const_o || valc_o == '0); // R5
    AST_LEN_LEGAL: assert (step == 1 || step == 2 || step == 5 || step == 6); // R6
    AST_BAD_SHORT: assert (!bad_op_o || (step == 1 && !has_reg_o && !has_const_o)); // R7
    AST_BAD_RANGE: assert (bad_op_o == (opcode_o > 4'hB)); // R7
  end

endmodule

bind ifd_fetch_decode ifd_fetch_decode_chk #(
  .ADDR_W  (ADDR_W),
  .WIN_W   (WIN_W),
  .CONST_W (CONST_W)
) u_chk (.*);

// File: tb/tb_ifd_fetch_decode.sv
module tb_ifd_fetch_decode;

  typedef struct packed {
    logic [47:0] win;
    logic [31:0] pc;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [31:0] valc;
    logic [31:0] valp;
    logic        bad;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{48'h112233445500, 32'h0000_0100, 4'h8, 4'h8, 32'h0,          32'h0000_0101, 1'b0}, // nop
    '{48'hAABBCCDDEE10, 32'h0000_0000, 4'h8, 4'h8, 32'h0,          32'h0000_0001, 1'b0}, // halt
    '{48'h998877663720, 32'h0000_0040, 4'h3, 4'h7, 32'h0,          32'h0000_0042, 1'b0}, // reg move
    '{48'h12345678F430, 32'h0000_1000, 4'hF, 4'h4, 32'h1234_5678,  32'h0000_1006, 1'b0}, // imm move
    '{48'hDEADBEEF1240, 32'h0000_2002, 4'h1, 4'h2, 32'hDEAD_BEEF,  32'h0000_2008, 1'b0}, // store
    '{48'h000000106550, 32'hFFFF_FFFC, 4'h6, 4'h5, 32'h0000_0010,  32'h0000_0002, 1'b0}, // load, wrap R8
    '{48'hFFFFFFFF0163, 32'h0000_0010, 4'h0, 4'h1, 32'h0,          32'h0000_0012, 1'b0}, // alu
    '{48'h991122334474, 32'h0000_0300, 4'h8, 4'h8, 32'h1122_3344,  32'h0000_0305, 1'b0}, // jump
    '{48'h550000020080, 32'h0000_0400, 4'h8, 4'h8, 32'h0000_0200,  32'h0000_0405, 1'b0}, // call
    '{48'h112233445590, 32'h0000_0500, 4'h8, 4'h8, 32'h0,          32'h0000_0501, 1'b0}, // ret
    '{48'h000000004FA0, 32'h0000_0600, 4'h4, 4'hF, 32'h0,          32'h0000_0602, 1'b0}, // push
    '{48'h123456787FB0, 32'hFFFF_FFFF, 4'h7, 4'hF, 32'h0,          32'h0000_0001, 1'b0}, // pop, wrap R8
    '{48'hFFFFFFFF12C5, 32'h0000_0700, 4'h8, 4'h8, 32'h0,          32'h0000_0701, 1'b1}, // bad C
    '{48'hFFFFFFFFFFF0, 32'h0000_0800, 4'h8, 4'h8, 32'h0,          32'h0000_0801, 1'b1}  // bad F
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_i;
  logic [47:0] win_i;
  logic [3:0]  opcode_o, func_o, ra_o, rb_o;
  logic        has_reg_o, has_const_o, bad_op_o;
  logic [31:0] valc_o, valp_o;

  int n_chk;
  int n_fail;
  bit done;

  ifd_fetch_decode dut (
    .pc_i        (pc_i),
    .win_i       (win_i),
    .opcode_o    (opcode_o),
    .func_o      (func_o),
    .has_reg_o   (has_reg_o),
    .has_const_o (has_const_o),
    .ra_o        (ra_o),
    .rb_o        (rb_o),
    .valc_o      (valc_o),
    .valp_o      (valp_o),
    .bad_op_o    (bad_op_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [47:0] w, input logic [31:0] p);
    @(negedge clk);
    win_i = w;
    pc_i  = p;
    #1;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    pc_i  = '0;
    win_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset-time state: all-zero window decodes as a 1-byte nop
    apply(48'h0, 32'h0);
    check("R1", "opcode", 32'(opcode_o), 32'h0);
    check("R3", "ra", 32'(ra_o), 32'h8);
    check("R5", "valc", valc_o, 32'h0);
    check("R6", "valp", valp_o, 32'h1);
    check("R7", "bad", 32'(bad_op_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].win, VECS[i].pc);
      check("R1", "opcode", 32'(opcode_o), 32'(VECS[i].win[7:4]));
      check("R1", "func", 32'(func_o), 32'(VECS[i].win[3:0]));
      check("R2_R3", "ra", 32'(ra_o), 32'(VECS[i].ra));
      check("R2_R3", "rb", 32'(rb_o), 32'(VECS[i].rb));
      check("R4_R5", "valc", valc_o, VECS[i].valc);
      check("R6_R8", "valp", valp_o, VECS[i].valp);
      check("R7", "bad", 32'(bad_op_o), 32'(VECS[i].bad));
    end

    // Sweep every opcode over a window with distinct lanes
    for (int op = 0; op < 16; op++) begin
      automatic bit reg_e, cst_e, bad_e;
      automatic int len_e;
      automatic logic [31:0] c_e;
      reg_e = (op inside {2, 3, 4, 5, 6, 10, 11});            // R2
      cst_e = (op inside {3, 4, 5, 7, 8});                    // R4
      bad_e = (op > 11);                                      // R7
      len_e = (op inside {3, 4, 5}) ? 6 : (op inside {7, 8}) ? 5 :
              (op inside {2, 6, 10, 11}) ? 2 : 1;             // R6
      c_e = !cst_e ? 32'h0 : reg_e ? 32'hF6E5_D4C3 : 32'hE5D4_C3B2;
      apply({8'hF6, 8'hE5, 8'hD4, 8'hC3, 8'hB2, 4'(op), 4'h9}, 32'h0000_8000);
      check("R2", "has_reg", 32'(has_reg_o), 32'(reg_e));
      check("R4", "has_const", 32'(has_const_o), 32'(cst_e));
      check("R3", "ra", 32'(ra_o), reg_e ? 32'hB : 32'h8);
      check("R4", "valc", valc_o, c_e);
      check("R6", "valp", valp_o, 32'h0000_8000 + 32'(len_e));
      check("R7", "bad", 32'(bad_op_o), 32'(bad_e));
    end

    // R5: constant lanes full of ones must not leak for a 2-byte op
    apply(48'hFFFFFFFFFF20, 32'h0);
    check("R5", "valc", valc_o, 32'h0);
    check("R2", "rb", 32'(rb_o), 32'hF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule